// File: doc/BRIEF.md
# I/O Port Address Decoder

This block turns each I/O cycle on a 16-bit address bus into chip selects and function strobes for the on-board devices. Those devices are the video gate array, the RAM banking latch, the CRT controller, the ROM select latch, the printer latch, the parallel peripheral interface, and an expansion space. The expansion space holds a floppy controller, a serial port, a reserved slot and user peripherals.

Decoding is partial. Each device watches one or two address bits and ignores the rest, so one address can select several devices in the same cycle. The gate array needs bit 15 low and bit 14 high. The CRT controller needs bit 14 low. These two conditions cannot both be true, so those two devices are never selected together.

A second-level decode inside the expansion space produces the floppy function strobes. A write to the expansion reset address produces a single-clock reset pulse. A read that would put more than one device on the data bus raises a conflict flag.

Top module: `io_port_decoder`

## Requirements
- R1: A cycle counts only when `iorq_n` is low and exactly one of `rd_n`/`wr_n` is low. In any other case every select and every floppy strobe is deasserted, `reg_idx` is 0, `rd_conflict` is 0 and no reset pulse is produced.
- R2: The following selects each respond to one low address bit and ignore every other bit:
  - ROM select responds to bit 13.
  - Printer responds to bit 12.
  - Parallel interface responds to bit 11.
  - Expansion space responds to bit 10.
- R3: The gate array is selected on a write with bit 15 = 0 and bit 14 = 1. The RAM latch is selected on a write with bit 15 = 0. The CRT controller is selected with bit 14 = 0. The gate array and the CRT controller are never selected in the same cycle.
- R4: Read cycles must not select the following:
  - The gate array, RAM latch, ROM select or printer.
  - The CRT controller when bits 9:8 are 00 or 01.
  - The parallel interface when bits 9:8 are 11.
- R5: During a valid cycle, `reg_idx` equals address bits 9:8.
- R6: Inside the expansion space (bit 10 = 0), each of the following bits selects one peripheral when it is low:
  - Bit 7 selects the floppy controller.
  - Bit 6 selects the reserved slot.
  - Bit 5 selects the serial port.
- R7: The user-expansion select asserts inside the expansion space when bits 7..5 are all high, except when bits 7..0 are all high.
- R8: The floppy strobes depend on bits 8 and 0:
  - Motor strobe: write with bit 8 = 0.
  - Status strobe: read with bit 8 = 1 and bit 0 = 0.
  - Data strobe: bit 8 = 1 and either a write or bit 0 = 1.
- R9: A write with bit 10 = 0 and bits 7..0 all high produces a pulse on `exp_rst`. The pulse goes high for exactly one clock after the first rising edge that samples that write. Holding the write does not retrigger it, a read does not trigger it, and synchronous reset clears it.
- R10: A write that matches several write-only latches asserts all of their selects in the same cycle.
- R11: `rd_conflict` is 1 on a read cycle in which two or more of the following are selected: CRT controller, parallel interface, floppy, serial, reserved, user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the reset-pulse register |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | I/O port address |
| iorq_n | input | 1 | I/O request qualifier, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ga_cs | output | 1 | Gate array select (active low by default) |
| ram_cs | output | 1 | RAM banking latch select |
| crtc_cs | output | 1 | CRT controller select |
| rom_cs | output | 1 | ROM select latch select |
| prn_cs | output | 1 | Printer latch select |
| ppi_cs | output | 1 | Parallel interface select |
| exp_cs | output | 1 | Expansion space select |
| fdc_cs | output | 1 | Floppy controller select |
| ser_cs | output | 1 | Serial port select |
| rsv_cs | output | 1 | Reserved expansion slot select |
| usr_cs | output | 1 | User expansion select |
| reg_idx | output | 2 | Register index for CRT controller and parallel interface |
| fdc_motor | output | 1 | Floppy motor latch write strobe |
| fdc_status | output | 1 | Floppy main status read strobe |
| fdc_data | output | 1 | Floppy data register strobe |
| exp_rst | output | 1 | Expansion reset pulse, active high |
| rd_conflict | output | 1 | Multi-device read flag, active high |

## Verification
Apart from the reset pulse, the decode has no state, so a wrong select term shows at the ports within the same cycle. It appears only at the addresses whose bit pattern reaches that term. For this reason every address is swept for both reads and writes and compared against a bench model.

The only stored state is the reset pulse's previous-hit register. If that register is wrong, one of two things shows one clock after a qualifying write: a pulse that stays high while the write is held, or a pulse that never appears. The directed pulse tests watch both edges of that window.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

   // Address bit positions the decode depends on
   localparam int unsigned B_GA_HI  = 15;
   localparam int unsigned B_CRTC   = 14;
   localparam int unsigned B_ROM    = 13;
   localparam int unsigned B_PRN    = 12;
   localparam int unsigned B_PPI    = 11;
   localparam int unsigned B_EXP    = 10;
   localparam int unsigned B_IDX_HI = 9;
   localparam int unsigned B_IDX_LO = 8;
   localparam int unsigned B_FDC    = 7;
   localparam int unsigned B_RSV    = 6;
   localparam int unsigned B_SER    = 5;
   localparam int unsigned B_FN0    = 0;

   localparam int unsigned IDX_W      = B_IDX_HI - B_IDX_LO + 1;
   localparam int unsigned MIN_ADDR_W = B_GA_HI + 1;
   localparam int unsigned NUM_RD_DEV = 6;   // devices that may drive read data

   typedef struct packed {
      logic ga;
      logic ram;
      logic crtc;
      logic rom;
      logic prn;
      logic ppi;
      logic exp;
   } main_sel_t;

   typedef struct packed {
      logic fdc;
      logic ser;
      logic rsv;
      logic usr;
   } exp_sel_t;

   typedef struct packed {
      logic motor;
      logic status;
      logic data;
   } fdc_fn_t;

endpackage

// File: rtl/io_cycle_qual.sv
module io_cycle_qual (
   input  logic iorq_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_cyc,
   output logic wr_cyc
);
   logic one_strobe;

   always_comb begin
      one_strobe = rd_n ^ wr_n;
      rd_cyc     = !iorq_n && one_strobe && !rd_n;
      wr_cyc     = !iorq_n && one_strobe && !wr_n;
   end
endmodule

// File: rtl/io_main_decode.sv
module io_main_decode
   import io_dec_pkg::*;
(
   input  logic       rd_cyc,
   input  logic       wr_cyc,
   input  logic [7:0] addr_hi,   // address bits 15..8
   output main_sel_t  sel
);
   localparam int unsigned OFS = 8;

   logic a_ga, a_crtc, a_rom, a_prn, a_ppi, a_exp, a_i1, a_i0;

   always_comb begin
      a_ga   = addr_hi[B_GA_HI  - OFS];
      a_crtc = addr_hi[B_CRTC   - OFS];
      a_rom  = addr_hi[B_ROM    - OFS];
      a_prn  = addr_hi[B_PRN    - OFS];
      a_ppi  = addr_hi[B_PPI    - OFS];
      a_exp  = addr_hi[B_EXP    - OFS];
      a_i1   = addr_hi[B_IDX_HI - OFS];
      a_i0   = addr_hi[B_IDX_LO - OFS];

      sel.ga   = wr_cyc && !a_ga && a_crtc;
      sel.ram  = wr_cyc && !a_ga;
      sel.crtc = !a_crtc && (wr_cyc || (rd_cyc && a_i1));
      sel.rom  = wr_cyc && !a_rom;
      sel.prn  = wr_cyc && !a_prn;
      sel.ppi  = !a_ppi && (wr_cyc || (rd_cyc && !(a_i1 && a_i0)));
      sel.exp  = (wr_cyc || rd_cyc) && !a_exp;
   end
endmodule

// File: rtl/io_exp_decode.sv
module io_exp_decode
   import io_dec_pkg::*;
(
   input  logic       exp_hit,
   input  logic       rd_cyc,
   input  logic       wr_cyc,
   input  logic       fn_hi,     // address bit 8
   input  logic [7:0] addr_lo,   // address bits 7..0
   output exp_sel_t   sel,
   output fdc_fn_t    fn,
   output logic       rst_hit
);
   logic low_all_ones;

   always_comb begin
      low_all_ones = &addr_lo;

      sel.fdc = exp_hit && !addr_lo[B_FDC];
      sel.rsv = exp_hit && !addr_lo[B_RSV];
      sel.ser = exp_hit && !addr_lo[B_SER];
      sel.usr = exp_hit && addr_lo[B_FDC] && addr_lo[B_RSV] && addr_lo[B_SER]
                && !low_all_ones;

      fn.motor  = sel.fdc && wr_cyc && !fn_hi;
      fn.status = sel.fdc && rd_cyc && fn_hi && !addr_lo[B_FN0];
      fn.data   = sel.fdc && fn_hi && (wr_cyc || addr_lo[B_FN0]);

      rst_hit = exp_hit && wr_cyc && low_all_ones;
   end
endmodule

// File: rtl/io_rst_pulse.sv
module io_rst_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse
);
   logic trig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         trig_q <= trig;
         pulse  <= trig && !trig_q;
      end
   end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
   import io_dec_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter bit          SEL_ACT_LOW = 1'b1,
   parameter int unsigned CONFLICT_MIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic              ga_cs,
   output logic              ram_cs,
   output logic              crtc_cs,
   output logic              rom_cs,
   output logic              prn_cs,
   output logic              ppi_cs,
   output logic              exp_cs,
   output logic              fdc_cs,
   output logic              ser_cs,
   output logic              rsv_cs,
   output logic              usr_cs,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              fdc_motor,
   output logic              fdc_status,
   output logic              fdc_data,
   output logic              exp_rst,
   output logic              rd_conflict
);
   localparam int unsigned CNT_W  = $clog2(NUM_RD_DEV + 1);
   localparam int unsigned SEL_NB = 14;

   if (ADDR_W != MIN_ADDR_W) begin : g_bad_addr_w
      $error("io_port_decoder: ADDR_W must be %0d", MIN_ADDR_W);
   end
   if (CONFLICT_MIN < 2 || CONFLICT_MIN > NUM_RD_DEV) begin : g_bad_conflict
      $error("io_port_decoder: CONFLICT_MIN out of range");
   end

   logic      rd_cyc, wr_cyc, rst_hit;
   main_sel_t msel;
   exp_sel_t  esel;
   fdc_fn_t   ffn;

   io_cycle_qual u_qual (
      .iorq_n (iorq_n),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .rd_cyc (rd_cyc),
      .wr_cyc (wr_cyc)
   );

   io_main_decode u_main (
      .rd_cyc  (rd_cyc),
      .wr_cyc  (wr_cyc),
      .addr_hi (addr[15:8]),
      .sel     (msel)
   );

   io_exp_decode u_exp (
      .exp_hit (msel.exp),
      .rd_cyc  (rd_cyc),
      .wr_cyc  (wr_cyc),
      .fn_hi   (addr[B_IDX_LO]),
      .addr_lo (addr[7:0]),
      .sel     (esel),
      .fn      (ffn),
      .rst_hit (rst_hit)
   );

   io_rst_pulse u_rst (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (rst_hit),
      .pulse (exp_rst)
   );

   // Read data contention detect
   logic [NUM_RD_DEV-1:0] rd_dev;
   logic [CNT_W-1:0]      rd_cnt;

   always_comb begin
      rd_dev = {msel.crtc, msel.ppi, esel.fdc, esel.ser, esel.rsv, esel.usr};
      rd_cnt = '0;
      for (int i = 0; i < NUM_RD_DEV; i++) begin
         rd_cnt = rd_cnt + CNT_W'(rd_dev[i]);
      end
      rd_conflict = rd_cyc && (rd_cnt >= CNT_W'(CONFLICT_MIN));
      reg_idx     = (rd_cyc || wr_cyc) ? addr[B_IDX_HI:B_IDX_LO] : '0;
   end

   // Output polarity
   logic [SEL_NB-1:0] sel_hi, sel_out;
   assign sel_hi = {msel.ga, msel.ram, msel.crtc, msel.rom, msel.prn, msel.ppi,
                    msel.exp, esel.fdc, esel.ser, esel.rsv, esel.usr,
                    ffn.motor, ffn.status, ffn.data};

   if (SEL_ACT_LOW) begin : g_act_low
      assign sel_out = ~sel_hi;
   end else begin : g_act_high
      assign sel_out = sel_hi;
   end

   assign {ga_cs, ram_cs, crtc_cs, rom_cs, prn_cs, ppi_cs, exp_cs,
           fdc_cs, ser_cs, rsv_cs, usr_cs, fdc_motor, fdc_status, fdc_data} = sel_out;

endmodule

// File: rtl/io_port_decoder_chk.sv
module io_port_decoder_chk #(
   parameter bit SEL_ACT_LOW = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       iorq_n,
   input logic       rd_n,
   input logic       wr_n,
   input logic       a_exp,
   input logic [7:0] a_lo,
   input logic       ga_cs,
   input logic       ram_cs,
   input logic       crtc_cs,
   input logic       rom_cs,
   input logic       prn_cs,
   input logic       fdc_cs,
   input logic       ser_cs,
   input logic       rsv_cs,
   input logic       usr_cs,
   input logic       exp_rst,
   input logic       rd_conflict
);
   localparam logic ON = SEL_ACT_LOW ? 1'b0 : 1'b1;

   logic any_on, wo_on, rst_write;
   assign any_on = (ga_cs == ON) || (ram_cs == ON) || (crtc_cs == ON) || (rom_cs == ON)
                   || (prn_cs == ON) || (fdc_cs == ON) || (ser_cs == ON)
                   || (rsv_cs == ON) || (usr_cs == ON);
   assign wo_on  = (ga_cs == ON) || (ram_cs == ON) || (rom_cs == ON) || (prn_cs == ON);
   assign rst_write = !iorq_n && !wr_n && rd_n && !a_exp && (&a_lo);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      iorq_n |-> (!any_on && !rd_conflict));

   a_r3_ga_crtc_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !((ga_cs == ON) && (crtc_cs == ON)));

   a_r4_no_wo_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && wr_n) |-> !wo_on);

   a_r7_usr_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_cs == ON) |-> ((fdc_cs != ON) && (ser_cs != ON) && (rsv_cs != ON)));

   a_r9_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      exp_rst |=> !exp_rst);

   a_r9_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
      exp_rst |-> $past(rst_write));

   a_r11_conflict_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_conflict |-> (!iorq_n && !rd_n && wr_n));
endmodule

bind io_port_decoder io_port_decoder_chk #(.SEL_ACT_LOW(SEL_ACT_LOW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .iorq_n      (iorq_n),
   .rd_n        (rd_n),
   .wr_n        (wr_n),
   .a_exp       (addr[10]),
   .a_lo        (addr[7:0]),
   .ga_cs       (ga_cs),
   .ram_cs      (ram_cs),
   .crtc_cs     (crtc_cs),
   .rom_cs      (rom_cs),
   .prn_cs      (prn_cs),
   .fdc_cs      (fdc_cs),
   .ser_cs      (ser_cs),
   .rsv_cs      (rsv_cs),
   .usr_cs      (usr_cs),
   .exp_rst     (exp_rst),
   .rd_conflict (rd_conflict)
);

// File: tb/tb_io_port_decoder.sv
module tb_io_port_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic        iorq_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;

   logic ga_cs, ram_cs, crtc_cs, rom_cs, prn_cs, ppi_cs, exp_cs;
   logic fdc_cs, ser_cs, rsv_cs, usr_cs, fdc_motor, fdc_status, fdc_data;
   logic exp_rst, rd_conflict;
   logic [1:0] reg_idx;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   io_port_decoder dut (
      .clk (clk), .rst_n (rst_n), .addr (addr), .iorq_n (iorq_n),
      .rd_n (rd_n), .wr_n (wr_n),
      .ga_cs (ga_cs), .ram_cs (ram_cs), .crtc_cs (crtc_cs), .rom_cs (rom_cs),
      .prn_cs (prn_cs), .ppi_cs (ppi_cs), .exp_cs (exp_cs), .fdc_cs (fdc_cs),
      .ser_cs (ser_cs), .rsv_cs (rsv_cs), .usr_cs (usr_cs), .reg_idx (reg_idx),
      .fdc_motor (fdc_motor), .fdc_status (fdc_status), .fdc_data (fdc_data),
      .exp_rst (exp_rst), .rd_conflict (rd_conflict)
   );

   // Observed outputs, active-high, order: ga ram crtc rom prn ppi exp fdc ser rsv usr
   // motor status data conflict idx[1:0]
   logic [16:0] obs;
   assign obs = {~ga_cs, ~ram_cs, ~crtc_cs, ~rom_cs, ~prn_cs, ~ppi_cs, ~exp_cs,
                 ~fdc_cs, ~ser_cs, ~rsv_cs, ~usr_cs,
                 ~fdc_motor, ~fdc_status, ~fdc_data, rd_conflict, reg_idx};

   function automatic logic [16:0] model(input logic [15:0] a, input logic rq_n,
                                         input logic r_n, input logic w_n);
      logic rd, wr, ga, ram, crtc, rom, prn, ppi, ex, fdc, ser, rsv, usr;
      logic mot, sta, dat, con;
      logic [1:0] idx;
      int cnt;
      rd   = !rq_n && !r_n && w_n;
      wr   = !rq_n && !w_n && r_n;
      ga   = wr && !a[15] && a[14];
      ram  = wr && !a[15];
      crtc = !a[14] && (wr || (rd && a[9:8] >= 2'd2));
      rom  = wr && !a[13];
      prn  = wr && !a[12];
      ppi  = !a[11] && (wr || (rd && a[9:8] != 2'd3));
      ex   = (rd || wr) && !a[10];
      fdc  = ex && !a[7];
      rsv  = ex && !a[6];
      ser  = ex && !a[5];
      usr  = ex && (a[7:5] == 3'b111) && (a[7:0] != 8'hFF);
      mot  = fdc && wr && !a[8];
      sta  = fdc && rd && a[8] && !a[0];
      dat  = fdc && a[8] && (wr || a[0]);
      cnt  = int'(crtc) + int'(ppi) + int'(fdc) + int'(ser) + int'(rsv) + int'(usr);
      con  = rd && (cnt >= 2);
      idx  = (rd || wr) ? a[9:8] : 2'b00;
      return {ga, ram, crtc, rom, prn, ppi, ex, fdc, ser, rsv, usr, mot, sta, dat, con, idx};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v,
                        input string what);
      n_checks++;
      if (act !== exp_v) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
      end
   endtask

   task automatic drive(input logic [15:0] a, input logic rq, input logic r, input logic w);
      addr = a; iorq_n = rq; rd_n = r; wr_n = w;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      drive(16'hFBFF, 1'b0, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      check("R9", {31'd0, exp_rst}, 32'd0, "pulse held low in reset");
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
      #1;
      check("R1", {15'd0, obs}, 32'd0, "outputs idle after reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_idle();
      drive(16'h0000, 1'b1, 1'b1, 1'b0);
      #1 check("R1", {15'd0, obs}, 32'd0, "iorq inactive, write strobe");
      drive(16'h0300, 1'b1, 1'b0, 1'b1);
      #1 check("R1", {15'd0, obs}, 32'd0, "iorq inactive, read strobe");
      drive(16'h0000, 1'b0, 1'b0, 1'b0);
      #1 check("R1", {15'd0, obs}, 32'd0, "both strobes active");
      @(negedge clk);
      drive(16'hFBFF, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      @(negedge clk);
      check("R1", {31'd0, exp_rst}, 32'd0, "no pulse without iorq");
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
   endtask

   task automatic t_sweep(input bit is_read);
      for (int a = 0; a < 65536; a += 2) begin
         @(negedge clk);
         for (int k = 0; k < 2; k++) begin
            drive(16'(a + k), 1'b0, !is_read, is_read);
            #1;
            check("R2/R3/R4/R5/R6/R7/R8/R11",
                  {15'd0, obs}, {15'd0, model(16'(a + k), 1'b0, !is_read, is_read)},
                  is_read ? "read sweep" : "write sweep");
            check("R3", {31'd0, (!ga_cs && !crtc_cs)}, 32'd0, "ga/crtc exclusion");
            #1;
         end
      end
      @(negedge clk);
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
   endtask

   task automatic t_multi_write();
      @(negedge clk);
      drive(16'h4FFF, 1'b0, 1'b1, 1'b0);
      #1 check("R10", {28'd0, ~ga_cs, ~ram_cs, ~rom_cs, ~prn_cs}, 32'hF, "ga+ram+rom+prn");
      check("R10", {31'd0, ~crtc_cs}, 32'd0, "crtc off with ga");
      drive(16'h0FFF, 1'b0, 1'b1, 1'b0);
      #1 check("R10", {28'd0, ~crtc_cs, ~ram_cs, ~rom_cs, ~prn_cs}, 32'hF, "crtc+ram+rom+prn");
      check("R10", {31'd0, ~ga_cs}, 32'd0, "ga off with crtc");
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic t_conflict();
      @(negedge clk);
      drive(16'hB37F, 1'b0, 1'b0, 1'b1);
      #1 check("R11", {31'd0, rd_conflict}, 32'd1, "crtc+fdc read");
      drive(16'hF37F, 1'b0, 1'b0, 1'b1);
      #1 check("R11", {31'd0, rd_conflict}, 32'd0, "fdc alone, ppi control excluded");
      drive(16'hF05F, 1'b0, 1'b0, 1'b1);
      #1 check("R11", {31'd0, rd_conflict}, 32'd1, "ppi+fdc+serial read");
      drive(16'hB37F, 1'b0, 1'b1, 1'b0);
      #1 check("R11", {31'd0, rd_conflict}, 32'd0, "write never flags");
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic t_fdc();
      @(negedge clk);
      drive(16'hFA7E, 1'b0, 1'b1, 1'b0);
      #1 check("R8", {29'd0, ~fdc_motor, ~fdc_status, ~fdc_data}, 32'h4, "motor write");
      drive(16'hFA7F, 1'b0, 1'b0, 1'b1);
      #1 check("R8", {29'd0, ~fdc_motor, ~fdc_status, ~fdc_data}, 32'h0, "read bit8=0");
      drive(16'hFB7E, 1'b0, 1'b0, 1'b1);
      #1 check("R8", {29'd0, ~fdc_motor, ~fdc_status, ~fdc_data}, 32'h2, "status read");
      drive(16'hFB7F, 1'b0, 1'b0, 1'b1);
      #1 check("R8", {29'd0, ~fdc_motor, ~fdc_status, ~fdc_data}, 32'h1, "data read");
      drive(16'hFB7E, 1'b0, 1'b1, 1'b0);
      #1 check("R8", {29'd0, ~fdc_motor, ~fdc_status, ~fdc_data}, 32'h1, "data write");
      drive(16'hFBFE, 1'b0, 1'b0, 1'b1);
      #1 check("R7", {31'd0, ~usr_cs}, 32'd1, "user select at xxFE");
      drive(16'hFBFF, 1'b0, 1'b0, 1'b1);
      #1 check("R7", {31'd0, ~usr_cs}, 32'd0, "no user select at reset address");
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic t_rst_pulse();
      @(negedge clk);
      drive(16'hFBFF, 1'b0, 1'b1, 1'b0);
      check("R9", {31'd0, exp_rst}, 32'd0, "low before edge");
      @(negedge clk);
      check("R9", {31'd0, exp_rst}, 32'd1, "pulse after first edge");
      @(negedge clk);
      check("R9", {31'd0, exp_rst}, 32'd0, "held write no retrigger");
      @(negedge clk);
      check("R9", {31'd0, exp_rst}, 32'd0, "still low while held");
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      drive(16'h7BFF, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      check("R9", {31'd0, exp_rst}, 32'd1, "second write pulses again");
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      drive(16'hFBFF, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      check("R9", {31'd0, exp_rst}, 32'd0, "read gives no pulse");
      drive(16'hFBFE, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      check("R9", {31'd0, exp_rst}, 32'd0, "xxFE write gives no pulse");
      drive(16'h0000, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_multi_write();
      t_conflict();
      t_fdc();
      t_rst_pulse();
      t_sweep(1'b0);
      t_sweep(1'b1);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

endmodule